// File: doc/BRIEF.md
# LCD Colour Palette with Pixel Format Conversion

This block holds the colour lookup table of an LCD controller. Software writes it as 128 words of 32 bits. Each word packs two 16-bit colour entries, so the table holds 256 entries in total. Every entry carries three 5-bit channels and one intensity flag, and the block ignores the flag.

On each word write the block does two things. It keeps the raw word so that software can read it back unchanged. It also converts both halves at once into the display's pixel format and stores the results. A static depth select picks that format: 8-bit 3:3:2, 15-bit 5:5:5, 16-bit 5:6:5, or 8:8:8 for 24- and 32-bit displays. The conversion first widens each 5-bit channel to 8 bits by appending three zero bits, then cuts each channel down to the width the format needs.

A separate lookup port takes an 8-bit pixel index and returns the stored converted colour one clock later. The scan-out path uses this port. Fetching pixels from memory and generating display timing belong to other blocks.

Top module: `lcd_palette_conv`

## Requirements
- R1: In the clock cycle after `rst` is released, both `rd_data` and `lu_pixel` read zero.
- R2: `rd_data` returns, one cycle after `rd_addr` is presented, the full 32-bit word most recently written to that address, including bits 15 and 31.
- R3: Entry index 2n is converted from bits [15:0] of word n, and entry index 2n+1 from bits [31:16].
- R4: With `depth_sel` = 0, an entry with red in bits [4:0], green in [9:5] and blue in [14:10] is stored as a 24-bit value. Bits [23:8] are zero and bits [7:0] are {red[4:2], green[4:2], blue[4:3]}.
- R5: With `depth_sel` = 1, the stored value is {9'b0, red[4:0], green[4:0], blue[4:0]}.
- R6: With `depth_sel` = 2, the stored value is {8'b0, red[4:0], green[4:0], 1'b0, blue[4:0]}, so the green channel gets a zero LSB.
- R7: With `depth_sel` of 3 or more, the stored value is {red,3'b0, green,3'b0, blue,3'b0}, with red in bits [23:16].
- R8: Bit 15 of each 16-bit entry (the intensity flag) has no effect on the converted value.
- R9: Changing `depth_sel` does not change entries that are already stored. Only entries written after the change use the new format.
- R10: `lu_pixel` shows the entry addressed by `lu_idx` exactly one clock after `lu_idx` changes, and not earlier.
- R11: Writing one word changes neither the raw nor the converted contents of any other word or entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| depth_sel | input | 3 | Output pixel format used by writes (0: 3:3:2, 1: 5:5:5, 2: 5:6:5, 3 or more: 8:8:8) |
| wr_en | input | 1 | Write strobe for one palette word |
| wr_addr | input | 7 | Word address of the write |
| wr_data | input | 32 | Two packed colour entries |
| rd_addr | input | 7 | Word address of the raw read-back |
| rd_data | output | 32 | Raw stored word, one cycle latency |
| lu_idx | input | 8 | Entry index for the lookup port |
| lu_pixel | output | 24 | Converted colour, zero-extended, one cycle latency |

## Verification
The checks that run on every clock cover the following. Both converter outputs must keep the zero bits that the current format requires. A raw word that is written and then read back at once must come back intact. The lookup output must hold steady while its index holds and no write arrives. The outputs must be clear right after reset.

Some properties only the bench scenarios can show. These are the exact bit positions of each channel in every format, and the even/odd placement of the two halves. They also include the fact that the intensity flag and later changes of the depth select leave stored colours untouched. The bench reads back every word and entry after all writes to show that no write disturbed another location.

// File: rtl/lcdpal_pkg.sv
package lcdpal_pkg;
  localparam int CH_W   = 5;            // raw channel width
  localparam int WIDE_W = 8;            // widened channel width
  localparam int PIX_W  = 3 * WIDE_W;   // converted pixel storage width

  typedef enum logic [2:0] {
    FMT_332 = 3'd0,
    FMT_555 = 3'd1,
    FMT_565 = 3'd2,
    FMT_888 = 3'd3,
    FMT_X888 = 3'd4
  } pix_fmt_e;
endpackage

// File: rtl/lcdpal_ram.sv
module lcdpal_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; read-first against a write to the same address.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcdpal_conv.sv
module lcdpal_conv
  import lcdpal_pkg::*;
(
  input  logic [3*CH_W-1:0] entry,   // {blue, green, red}, intensity bit excluded
  input  pix_fmt_e          fmt,
  output logic [PIX_W-1:0]  pix
);
  logic [WIDE_W-1:0] r8, g8, b8;

  always_comb begin
    r8 = {entry[CH_W-1:0],        {(WIDE_W-CH_W){1'b0}}};
    g8 = {entry[2*CH_W-1:CH_W],   {(WIDE_W-CH_W){1'b0}}};
    b8 = {entry[3*CH_W-1:2*CH_W], {(WIDE_W-CH_W){1'b0}}};
    case (fmt)
      FMT_332: pix = {16'b0, r8[7:5], g8[7:5], b8[7:6]};
      FMT_555: pix = {9'b0,  r8[7:3], g8[7:3], b8[7:3]};
      FMT_565: pix = {8'b0,  r8[7:3], g8[7:2], b8[7:3]};
      default: pix = {r8, g8, b8};
    endcase
  end
endmodule

// File: rtl/lcd_palette_conv.sv
module lcd_palette_conv
  import lcdpal_pkg::*;
#(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int ENTRIES = 2 * WORDS,
  localparam int WA_W    = $clog2(WORDS),
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ENTRY_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        depth_sel,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WA_W-1:0]   rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lu_idx,
  output logic [PIX_W-1:0]  lu_pixel
);
  pix_fmt_e         fmt;
  logic [PIX_W-1:0] conv_pix [2];
  logic [PIX_W-1:0] bank_q   [2];
  logic             lu_half_q;

  assign fmt = pix_fmt_e'(depth_sel);

  // Raw word store for read-back.
  lcdpal_ram #(.WIDTH(WORD_W), .DEPTH(WORDS)) u_raw (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // One converter and one converted bank per half-word: half 0 feeds even
  // entries, half 1 feeds odd entries, so both update in the same write.
  for (genvar h = 0; h < 2; h++) begin : g_half
    lcdpal_conv u_conv (
      .entry(wr_data[h*ENTRY_W +: 3*CH_W]),
      .fmt(fmt),
      .pix(conv_pix[h])
    );
    lcdpal_ram #(.WIDTH(PIX_W), .DEPTH(WORDS)) u_bank (
      .clk(clk), .rst(rst),
      .we(wr_en), .waddr(wr_addr), .wdata(conv_pix[h]),
      .raddr(lu_idx[IDX_W-1:1]), .rdata(bank_q[h])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lu_half_q <= 1'b0;
    else     lu_half_q <= lu_idx[0];
  end

  assign lu_pixel = bank_q[lu_half_q];
endmodule

// File: rtl/lcdpal_chk.sv
module lcdpal_chk #(
  parameter int WA_W   = 7,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8,
  parameter int PIX_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        depth_sel,
  input logic              wr_en,
  input logic [WA_W-1:0]   wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [WA_W-1:0]   rd_addr,
  input logic [WORD_W-1:0] rd_data,
  input logic [IDX_W-1:0]  lu_idx,
  input logic [PIX_W-1:0]  lu_pixel,
  input logic [PIX_W-1:0]  conv_lo,
  input logic [PIX_W-1:0]  conv_hi
);
  logic [1:0] live;  // edges seen since reset, saturating at 3

  always_ff @(posedge clk) begin
    if (rst)            live <= '0;
    else if (live != 3) live <= live + 2'd1;
  end

  assert_clear_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (rd_data == '0 && lu_pixel == '0));

  assert_raw_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (live == 3 && $past(wr_en, 2) && !$past(wr_en) && $past(rd_addr) == $past(wr_addr, 2))
      |-> rd_data == $past(wr_data, 2));

  assert_fmt332_zero_R4: assert property (@(posedge clk) disable iff (rst)
    depth_sel == 3'd0 |-> (conv_lo[23:8] == '0 && conv_hi[23:8] == '0));

  assert_fmt555_zero_R5: assert property (@(posedge clk) disable iff (rst)
    depth_sel == 3'd1 |-> (conv_lo[23:15] == '0 && conv_hi[23:15] == '0));

  assert_fmt565_zero_R6: assert property (@(posedge clk) disable iff (rst)
    depth_sel == 3'd2 |-> (conv_lo[23:16] == '0 && conv_hi[23:16] == '0
                           && !conv_lo[5] && !conv_hi[5]));

  assert_fmt888_low_R7: assert property (@(posedge clk) disable iff (rst)
    depth_sel >= 3'd3 |-> (conv_lo[2:0] == '0 && conv_lo[10:8] == '0 && conv_lo[18:16] == '0
                           && conv_hi[2:0] == '0 && conv_hi[10:8] == '0 && conv_hi[18:16] == '0));

  assert_lookup_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (live == 3 && !$past(wr_en, 2) && !$past(wr_en) && $past(lu_idx) == $past(lu_idx, 2))
      |-> $stable(lu_pixel));
endmodule

bind lcd_palette_conv lcdpal_chk #(
  .WA_W(WA_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .PIX_W(PIX_W)
) u_lcdpal_chk (
  .clk(clk), .rst(rst), .depth_sel(depth_sel),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data),
  .lu_idx(lu_idx), .lu_pixel(lu_pixel),
  .conv_lo(conv_pix[0]), .conv_hi(conv_pix[1])
);

// File: tb/test_lcd_palette_conv.sv
module test_lcd_palette_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  depth_sel = '0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  lu_idx = '0;
  logic [23:0] lu_pixel;

  int applied = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  lcd_palette_conv i_lcd_palette_conv (
    .clk(clk), .rst(rst), .depth_sel(depth_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .lu_idx(lu_idx), .lu_pixel(lu_pixel)
  );

  // {depth[89:87], addr[86:80], word[79:48], even entry[47:24], odd entry[23:0]}
  localparam int NV = 9;
  localparam logic [89:0] VEC [NV] = '{
    {3'd0, 7'd0,   32'h03E0_001F, 24'h0000E0, 24'h00001C},  // R4 pure red / green
    {3'd0, 7'd1,   32'hFFFF_7C00, 24'h000003, 24'h0000FF},  // R4 blue, R8 flag set
    {3'd1, 7'd2,   32'h7C00_001F, 24'h007C00, 24'h00001F},  // R5
    {3'd2, 7'd3,   32'h8421_03E0, 24'h0007C0, 24'h000841},  // R6 green LSB zero, R8
    {3'd3, 7'd4,   32'h7FFF_0421, 24'h080808, 24'hF8F8F8},  // R7 depth 3
    {3'd4, 7'd5,   32'h7C00_001F, 24'hF80000, 24'h0000F8},  // R7 depth 4, red high
    {3'd1, 7'd127, 32'h7FFF_0000, 24'h000000, 24'h007FFF},  // R5 top word
    {3'd2, 7'd64,  32'hFFFF_7FFF, 24'h00FFDF, 24'h00FFDF},  // R6, R8 halves agree
    {3'd0, 7'd6,   32'h0000_5294, 24'h0000B6, 24'h000000}   // R4 mixed channels
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] d, input logic [6:0] a, input logic [31:0] w);
    @(negedge clk);
    depth_sel = d; wr_en = 1'b1; wr_addr = a; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_raw(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic get_pix(input logic [7:0] i, output logic [23:0] v);
    @(negedge clk);
    lu_idx = i;
    @(negedge clk);
    v = lu_pixel;
  endtask

  task automatic verify_vec(input int k, input string tag);
    logic [31:0] raw;
    logic [23:0] px;
    get_raw(VEC[k][86:80], raw);
    check({tag, " R2 raw word"}, raw, VEC[k][79:48]);
    get_pix({VEC[k][86:80], 1'b0}, px);
    check({tag, " R3 even entry"}, {8'h0, px}, {8'h0, VEC[k][47:24]});
    get_pix({VEC[k][86:80], 1'b1}, px);
    check({tag, " R3 odd entry"}, {8'h0, px}, {8'h0, VEC[k][23:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    logic [23:0] px;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 lu_pixel after reset", {8'h0, lu_pixel}, 32'h0);

    // Table walk: write each vector, then read it back both ways.
    for (int k = 0; k < NV; k++) begin
      put(VEC[k][89:87], VEC[k][86:80], VEC[k][79:48]);
      verify_vec(k, "vector");
    end

    // R11 and R9: every word intact after later writes and depth changes.
    depth_sel = 3'd3;
    for (int k = 0; k < NV; k++) verify_vec(k, "R11 R9 recheck");

    // R9: stored entry keeps its format across a depth change.
    put(3'd3, 7'd10, 32'h001F_001F);
    depth_sel = 3'd0;
    get_pix(8'd20, px);
    check("R9 old entry after depth change", {8'h0, px}, 32'h00F8_0000);
    put(3'd0, 7'd11, 32'h001F_001F);
    get_pix(8'd22, px);
    check("R9 new entry uses new format", {8'h0, px}, 32'h0000_00E0);

    // R10: exactly one cycle of lookup latency.
    get_pix(8'd0, px);
    @(negedge clk);
    lu_idx = 8'd1;
    #1;
    check("R10 value before edge", {8'h0, lu_pixel}, 32'h0000_00E0);
    @(negedge clk);
    check("R10 value after one edge", {8'h0, lu_pixel}, 32'h0000_001C);

    // R1: a second reset clears the outputs again.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rd_data after second reset", rd_data, 32'h0);
    check("R1 lu_pixel after second reset", {8'h0, lu_pixel}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule